// File: doc/BRIEF.md
# FP/SIMD Trap Gate

This block decides, in one pass of logic, whether a floating-point or SIMD instruction has to be stopped by an access trap. It also decides which privilege level (1, 2 or 3) takes the trap. It looks at the current privilege level and a small set of control inputs, and produces a trap flag, a target level, an exception class and a 25-bit syndrome word. The inputs are the level-1 and level-2 enable fields, the level-2 and level-3 trap bits, the host-mode and routing flags, and the condition syndrome.

There are three independent checks, one for each controlling level. A fixed priority picks the first one that fires, in the order level 1, then level 2, then level 3. A level-1 trap is normally taken at level 1. When level 2 is enabled and the route-to-level-2 flag (`tge`) is set, that trap is moved to level 2 and reported with the uncategorized class. By default the result is held in an output register, so each answer appears one clock after its inputs. Exception entry itself belongs to the consumer.

Top module: `fpsimd_trap_gate`

## Requirements
- R1: The level-1 check fires only when `cur_lvl` is 0 or 1 and `in_host` is 0. Its enable field `l1_fen` behaves as follows:
  - bit 0 equal to 0 (values 00 and 10) always fires;
  - 01 fires only at level 0;
  - 11 never fires.
- R2: The level-2 check can fire only when `lvl2_on` is 1 and `cur_lvl` is 0, 1 or 2.
- R3: When `host_ext` and `e2h` are both 1, the level-2 check decodes `l2_fen` as follows, and `l2_tfp` has no effect:
  - bit 0 equal to 0 fires unless `cur_lvl` is 1 with `tge` = 1;
  - 01 fires only at level 0 with `tge` = 1;
  - 11 never fires.
- R4: When `host_ext` and `e2h` are not both 1, the level-2 check fires exactly when `l2_tfp` is 1, and `l2_fen` has no effect.
- R5: The level-3 check fires at any current level when both `l3_present` and `l3_tfp` are 1. It gives target level 3.
- R6: The priority is level-1 check first, then level-2 check, then level-3 check. The target level is that of the first check that fires (1, 2 or 3, encoded as binary 2'd1, 2'd2, 2'd3).
- R7: If the level-1 check fires with `lvl2_on` = 1 and `tge` = 1, the result is as follows:
  - target level is 2;
  - `trap_cls` is 1 (uncategorized);
  - the whole syndrome is zero.
- R8: In every other trap, `trap_cls` is 0 (FP/SIMD access). `syndrome[24:20]` equals `cond_syn` and `syndrome[19:0]` is zero.
- R9: When no check fires, `trap_valid`, `trap_lvl`, `trap_cls` and `syndrome` are all zero.
- R10: With the default `REG_OUT` = 1, the outputs show the decision for the inputs present at the previous rising clock edge. While `rst_n` is low at a rising edge, the outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| in_host | input | 1 | Executing in host mode (suppresses the level-1 check) |
| lvl2_on | input | 1 | Level 2 is enabled for the current state |
| host_ext | input | 1 | Host extension is implemented |
| e2h | input | 1 | Host-extension layout selected for level-2 control |
| tge | input | 1 | Route-to-level-2 flag |
| l1_fen | input | 2 | Level-1 FP/SIMD enable field |
| l2_fen | input | 2 | Level-2 FP/SIMD enable field (host-extension layout) |
| l2_tfp | input | 1 | Level-2 trap bit (plain layout) |
| l3_tfp | input | 1 | Level-3 trap bit |
| l3_present | input | 1 | Level 3 is implemented |
| cond_syn | input | 5 | Condition syndrome to report |
| trap_valid | output | 1 | A trap must be taken |
| trap_lvl | output | 2 | Target privilege level |
| trap_cls | output | 1 | 0 = FP/SIMD access, 1 = uncategorized |
| syndrome | output | 25 | Syndrome word |

## Verification
Every result from the gate is due exactly one rising edge after the inputs that produced it, because the default build registers all outputs. The driver changes inputs on the falling edge and queues the expected outcome. The monitor pops one entry per cycle 2 ns after the next rising edge, so it always compares against the decision for the inputs that edge captured. Directed cases for each decode and routing corner come before an exhaustive sweep of all 16384 control combinations, in which the condition syndrome varies.

// File: rtl/fpt_pkg.sv
// Package: shared types and encodings for the FP/SIMD trap gate.
// Assumes privilege levels are 2-bit unsigned values 0..3.
package fpt_pkg;
    localparam int LVL_W = 2;

    localparam logic [LVL_W-1:0] LVL0 = 2'd0;
    localparam logic [LVL_W-1:0] LVL1 = 2'd1;
    localparam logic [LVL_W-1:0] LVL2 = 2'd2;
    localparam logic [LVL_W-1:0] LVL3 = 2'd3;

    typedef enum logic {
        CLS_FPSIMD = 1'b0,
        CLS_UNCAT  = 1'b1
    } trap_cls_e;
endpackage

// File: rtl/fpt_l1_check.sv
// Module: level-1 enable-field check.
// Fires when the level-1 enable field forbids FP/SIMD at the current level.
// Assumes in_host already folds in every condition that bypasses level-1 control.
module fpt_l1_check
    import fpt_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             in_host,
    input  logic [1:0]       fen,
    output logic             hit
);
    logic applies;

    // Decode the enable field when the check is in scope.
    always_comb begin
        applies = (cur_lvl == LVL0 || cur_lvl == LVL1) && !in_host;
        hit     = 1'b0;
        if (applies) begin
            if (!fen[0])
                hit = 1'b1;
            else if (!fen[1])
                hit = (cur_lvl == LVL0);
            else
                hit = 1'b0;
        end
    end
endmodule

// File: rtl/fpt_l2_check.sv
// Module: level-2 check, covering both control layouts.
// With host extension and e2h set, the 2-bit field is decoded against tge;
// otherwise the single trap bit decides. Assumes lvl2_on is already qualified.
module fpt_l2_check
    import fpt_pkg::*;
(
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             lvl2_on,
    input  logic             host_ext,
    input  logic             e2h,
    input  logic             tge,
    input  logic [1:0]       fen,
    input  logic             tfp,
    output logic             hit
);
    logic host_layout;
    logic applies;

    // Pick the layout and evaluate the trap condition.
    always_comb begin
        host_layout = host_ext && e2h;
        applies     = lvl2_on && (cur_lvl != LVL3);
        hit         = 1'b0;
        if (applies) begin
            if (host_layout) begin
                if (!fen[0])
                    hit = !(cur_lvl == LVL1 && tge);
                else if (!fen[1])
                    hit = (cur_lvl == LVL0) && tge;
                else
                    hit = 1'b0;
            end else begin
                hit = tfp;
            end
        end
    end
endmodule

// File: rtl/fpt_l3_check.sv
// Module: level-3 check. Fires whenever level 3 exists and its trap bit is set,
// independent of the current level.
module fpt_l3_check (
    input  logic present,
    input  logic tfp,
    output logic hit
);
    // Single gating term.
    always_comb hit = present && tfp;
endmodule

// File: rtl/fpt_route.sv
// Module: priority select and result build.
// Takes the three check hits, picks the first in level order and forms level,
// class and syndrome. Assumes COND_W < SYN_W.
module fpt_route
    import fpt_pkg::*;
#(
    parameter int COND_W = 5,
    parameter int SYN_W  = 25
) (
    input  logic              l1_hit,
    input  logic              l2_hit,
    input  logic              l3_hit,
    input  logic              lvl2_on,
    input  logic              tge,
    input  logic [COND_W-1:0] cond_syn,
    output logic              valid,
    output logic [LVL_W-1:0]  lvl,
    output trap_cls_e         cls,
    output logic [SYN_W-1:0]  syn
);
    localparam int ISS_W = SYN_W - COND_W;

    logic [SYN_W-1:0] fp_syn;

    // Syndrome used for every FP/SIMD-class trap.
    always_comb fp_syn = {cond_syn, {ISS_W{1'b0}}};

    // Fixed-priority selection: level 1, then 2, then 3.
    always_comb begin
        valid = 1'b0;
        lvl   = LVL0;
        cls   = CLS_FPSIMD;
        syn   = '0;
        if (l1_hit) begin
            valid = 1'b1;
            if (lvl2_on && tge) begin
                lvl = LVL2;
                cls = CLS_UNCAT;
                syn = '0;
            end else begin
                lvl = LVL1;
                syn = fp_syn;
            end
        end else if (l2_hit) begin
            valid = 1'b1;
            lvl   = LVL2;
            syn   = fp_syn;
        end else if (l3_hit) begin
            valid = 1'b1;
            lvl   = LVL3;
            syn   = fp_syn;
        end
    end
endmodule

// File: rtl/fpsimd_trap_gate.sv
// Module: top of the FP/SIMD trap gate.
// Runs the three level checks in parallel, routes by priority and optionally
// registers the result (REG_OUT=1 gives one cycle of latency).
// Assumes a synchronous active-low reset on clk.
module fpsimd_trap_gate
    import fpt_pkg::*;
#(
    parameter int COND_W  = 5,
    parameter int SYN_W   = 25,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cur_lvl,
    input  logic              in_host,
    input  logic              lvl2_on,
    input  logic              host_ext,
    input  logic              e2h,
    input  logic              tge,
    input  logic [1:0]        l1_fen,
    input  logic [1:0]        l2_fen,
    input  logic              l2_tfp,
    input  logic              l3_tfp,
    input  logic              l3_present,
    input  logic [COND_W-1:0] cond_syn,
    output logic              trap_valid,
    output logic [1:0]        trap_lvl,
    output logic              trap_cls,
    output logic [SYN_W-1:0]  syndrome
);
    localparam int ISS_W = SYN_W - COND_W;

    logic             l1_hit, l2_hit, l3_hit;
    logic             nxt_valid;
    logic [LVL_W-1:0] nxt_lvl;
    trap_cls_e        nxt_cls;
    logic [SYN_W-1:0] nxt_syn;

    fpt_l1_check u_l1 (
        .cur_lvl (cur_lvl),
        .in_host (in_host),
        .fen     (l1_fen),
        .hit     (l1_hit)
    );

    fpt_l2_check u_l2 (
        .cur_lvl  (cur_lvl),
        .lvl2_on  (lvl2_on),
        .host_ext (host_ext),
        .e2h      (e2h),
        .tge      (tge),
        .fen      (l2_fen),
        .tfp      (l2_tfp),
        .hit      (l2_hit)
    );

    fpt_l3_check u_l3 (
        .present (l3_present),
        .tfp     (l3_tfp),
        .hit     (l3_hit)
    );

    fpt_route #(.COND_W(COND_W), .SYN_W(SYN_W)) u_route (
        .l1_hit   (l1_hit),
        .l2_hit   (l2_hit),
        .l3_hit   (l3_hit),
        .lvl2_on  (lvl2_on),
        .tge      (tge),
        .cond_syn (cond_syn),
        .valid    (nxt_valid),
        .lvl      (nxt_lvl),
        .cls      (nxt_cls),
        .syn      (nxt_syn)
    );

    // Check gating, next to the checks' outputs.
    AST_L1_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_lvl > LVL1 || in_host) |-> !l1_hit); // R1
    AST_L2_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lvl2_on || cur_lvl == LVL3) |-> !l2_hit); // R2
    AST_L3_NEEDS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        l3_hit |-> l3_present); // R5

    // Routing invariants across the check/route boundary.
    AST_L1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        l1_hit |-> (nxt_valid && (nxt_lvl == LVL1 || nxt_cls == CLS_UNCAT))); // R6
    AST_L3_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_valid && nxt_lvl == LVL3) |-> (!l1_hit && !l2_hit)); // R6
    AST_REROUTE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_valid && nxt_cls == CLS_UNCAT) |-> (nxt_lvl == LVL2 && nxt_syn == '0)); // R7
    AST_FP_SYNDROME: assert property (@(posedge clk) disable iff (!rst_n)
        (nxt_valid && nxt_cls == CLS_FPSIMD) |->
        (nxt_syn[SYN_W-1:ISS_W] == cond_syn && nxt_syn[ISS_W-1:0] == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !nxt_valid |-> (nxt_lvl == LVL0 && nxt_cls == CLS_FPSIMD && nxt_syn == '0)); // R9

    generate
        if (REG_OUT) begin : g_reg
            // Capture the routed decision, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    trap_valid <= 1'b0;
                    trap_lvl   <= LVL0;
                    trap_cls   <= 1'b0;
                    syndrome   <= '0;
                end else begin
                    trap_valid <= nxt_valid;
                    trap_lvl   <= nxt_lvl;
                    trap_cls   <= nxt_cls;
                    syndrome   <= nxt_syn;
                end
            end

            AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (trap_valid == $past(nxt_valid)
                                  && trap_lvl == $past(nxt_lvl)
                                  && syndrome == $past(nxt_syn))); // R10
        end else begin : g_comb
            // Pass the decision straight through.
            always_comb begin
                trap_valid = nxt_valid;
                trap_lvl   = nxt_lvl;
                trap_cls   = nxt_cls;
                syndrome   = nxt_syn;
            end
        end
    endgenerate
endmodule

// File: tb/fpsimd_trap_gate_test.sv
// Scoreboard bench: driver queues expected results, monitor compares them.
module fpsimd_trap_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cur_lvl = 2'd0;
    logic        in_host = 1'b0, lvl2_on = 1'b0, host_ext = 1'b0, e2h = 1'b0, tge = 1'b0;
    logic [1:0]  l1_fen = 2'b11, l2_fen = 2'b11;
    logic        l2_tfp = 1'b0, l3_tfp = 1'b0, l3_present = 1'b0;
    logic [4:0]  cond_syn = 5'd0;
    logic        trap_valid, trap_cls;
    logic [1:0]  trap_lvl;
    logic [24:0] syndrome;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic        v;
        logic [1:0]  l;
        logic        c;
        logic [24:0] s;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    fpsimd_trap_gate uut (
        .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .in_host(in_host),
        .lvl2_on(lvl2_on), .host_ext(host_ext), .e2h(e2h), .tge(tge),
        .l1_fen(l1_fen), .l2_fen(l2_fen), .l2_tfp(l2_tfp), .l3_tfp(l3_tfp),
        .l3_present(l3_present), .cond_syn(cond_syn),
        .trap_valid(trap_valid), .trap_lvl(trap_lvl), .trap_cls(trap_cls),
        .syndrome(syndrome)
    );

    // Expected outcome from the requirements, from the current input registers.
    function automatic exp_t model(string tag);
        exp_t e;
        logic a1, a2, a3;
        a1 = (cur_lvl <= 2'd1) && !in_host &&
             (!l1_fen[0] || (l1_fen == 2'b01 && cur_lvl == 2'd0));          // R1
        a2 = 1'b0;
        if (lvl2_on && cur_lvl != 2'd3) begin                                 // R2
            if (host_ext && e2h)                                              // R3
                a2 = !l2_fen[0] ? !(cur_lvl == 2'd1 && tge)
                   : (l2_fen == 2'b01) ? (cur_lvl == 2'd0 && tge) : 1'b0;
            else
                a2 = l2_tfp;                                                  // R4
        end
        a3 = l3_present && l3_tfp;                                            // R5
        e.tag = tag;
        e.v = a1 || a2 || a3;
        e.l = 2'd0; e.c = 1'b0; e.s = '0;                                     // R9
        if (a1 && lvl2_on && tge) begin                                       // R7
            e.l = 2'd2; e.c = 1'b1;
        end else if (e.v) begin                                               // R6, R8
            e.l = a1 ? 2'd1 : (a2 ? 2'd2 : 2'd3);
            e.s = {cond_syn, 20'd0};
        end
        return e;
    endfunction

    task automatic apply(string tag);
        q.push_back(model(tag));
    endtask

    task automatic set_in(input logic [1:0] lv, input logic hs, input logic on2,
                          input logic hx, input logic eh, input logic tg,
                          input logic [1:0] f1, input logic [1:0] f2,
                          input logic t2, input logic t3, input logic p3,
                          input logic [4:0] cs, input string tag);
        @(negedge clk);
        cur_lvl = lv; in_host = hs; lvl2_on = on2; host_ext = hx; e2h = eh; tge = tg;
        l1_fen = f1; l2_fen = f2; l2_tfp = t2; l3_tfp = t3; l3_present = p3; cond_syn = cs;
        apply(tag);
    endtask

    // Monitor: pop one expected item per cycle, just after the capturing edge.
    always @(posedge clk) begin
        #2;
        if (rst_n && q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (trap_valid !== e.v || trap_lvl !== e.l || trap_cls !== e.c || syndrome !== e.s) begin
                errors++;
                $display("FAIL %s: got v=%0d l=%0d c=%0d s=%h expected v=%0d l=%0d c=%0d s=%h",
                         e.tag, trap_valid, trap_lvl, trap_cls, syndrome, e.v, e.l, e.c, e.s);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Reset with trapping inputs present: outputs must stay zero (R10).
        l1_fen = 2'b00; l3_present = 1'b1; l3_tfp = 1'b1; cond_syn = 5'h1f;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (trap_valid !== 1'b0 || trap_lvl !== 2'd0 || trap_cls !== 1'b0 || syndrome !== '0) begin
            errors++;
            $display("FAIL R10 reset: got v=%0d l=%0d c=%0d s=%h expected all zero",
                     trap_valid, trap_lvl, trap_cls, syndrome);
        end
        @(negedge clk);
        rst_n = 1'b1;
        l1_fen = 2'b11; l3_present = 1'b0; l3_tfp = 1'b0; cond_syn = 5'd0;

        // args: lvl host on2 hext e2h tge f1 f2 t2 t3 p3 cond
        set_in(2'd0, 0, 0, 0, 0, 0, 2'b11, 2'b11, 0, 0, 0, 5'h0a, "R9_idle");
        set_in(2'd1, 0, 0, 0, 0, 0, 2'b00, 2'b11, 0, 0, 0, 5'h13, "R1_fen00_l1");
        set_in(2'd1, 0, 0, 0, 0, 0, 2'b10, 2'b11, 0, 0, 0, 5'h05, "R1_fen10_l1");
        set_in(2'd1, 0, 0, 0, 0, 0, 2'b01, 2'b11, 0, 0, 0, 5'h05, "R1_fen01_l1_pass");
        set_in(2'd0, 0, 0, 0, 0, 0, 2'b01, 2'b11, 0, 0, 0, 5'h07, "R1_fen01_l0");
        set_in(2'd0, 1, 0, 0, 0, 0, 2'b00, 2'b11, 0, 0, 0, 5'h07, "R1_host_skip");
        set_in(2'd2, 0, 0, 0, 0, 0, 2'b00, 2'b11, 0, 0, 0, 5'h07, "R1_l2_skip");
        set_in(2'd2, 0, 1, 0, 0, 0, 2'b11, 2'b11, 1, 0, 0, 5'h11, "R4_tfp_l2");
        set_in(2'd2, 0, 0, 0, 0, 0, 2'b11, 2'b11, 1, 0, 0, 5'h11, "R2_off");
        set_in(2'd3, 0, 1, 0, 0, 0, 2'b11, 2'b11, 1, 0, 0, 5'h11, "R2_lvl3_skip");
        set_in(2'd1, 0, 1, 1, 1, 1, 2'b11, 2'b00, 0, 0, 0, 5'h02, "R3_x0_l1_tge");
        set_in(2'd1, 0, 1, 1, 1, 0, 2'b11, 2'b10, 0, 0, 0, 5'h02, "R3_x0_l1");
        set_in(2'd0, 0, 1, 1, 1, 1, 2'b11, 2'b01, 0, 0, 0, 5'h1c, "R3_01_l0_tge");
        set_in(2'd0, 0, 1, 1, 1, 0, 2'b11, 2'b01, 0, 0, 0, 5'h1c, "R3_01_l0_notge");
        set_in(2'd2, 0, 1, 1, 1, 0, 2'b11, 2'b11, 1, 0, 0, 5'h1c, "R3_11_tfp_ignored");
        set_in(2'd2, 0, 1, 1, 0, 0, 2'b00, 2'b00, 0, 0, 0, 5'h1c, "R4_fen_ignored");
        set_in(2'd3, 0, 0, 0, 0, 0, 2'b11, 2'b11, 0, 1, 1, 5'h0f, "R5_l3");
        set_in(2'd3, 0, 0, 0, 0, 0, 2'b11, 2'b11, 0, 1, 0, 5'h0f, "R5_absent");
        set_in(2'd1, 0, 1, 0, 0, 0, 2'b00, 2'b11, 1, 1, 1, 5'h09, "R6_l1_wins");
        set_in(2'd2, 0, 1, 0, 0, 0, 2'b11, 2'b11, 1, 1, 1, 5'h09, "R6_l2_wins");
        set_in(2'd0, 0, 1, 0, 0, 1, 2'b00, 2'b11, 0, 0, 0, 5'h1f, "R7_reroute");
        set_in(2'd0, 0, 0, 0, 0, 1, 2'b00, 2'b11, 0, 0, 0, 5'h1f, "R7_no_l2");
        set_in(2'd1, 0, 0, 0, 0, 0, 2'b00, 2'b11, 0, 0, 0, 5'h15, "R8_fp_syn");

        // Exhaustive sweep of the control inputs (R6 overall priority).
        for (int i = 0; i < 16384; i++) begin
            logic [13:0] b;
            b = i[13:0];
            set_in(b[1:0], b[2], b[3], b[4], b[5], b[6], b[8:7], b[10:9], b[11], b[12], b[13],
                   b[4:0] ^ b[13:9], "R6_sweep");
        end

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule